// File: doc/BRIEF.md
# Prioritised Two-Pin Fault Flag Encoder

This block collects the fault indications of a set of half-bridge outputs and reports the most important active fault on two active-low flag pins. Three kinds of fault are reported. The first is an overcurrent event, which arrives already qualified by the shutdown timer. The second is an open load, built inside the block from raw low-side undercurrent comparator bits and the low-side gate status. The third is a global supply overvoltage or overtemperature status. Each kind keeps its own persistence rule. Overcurrent stays latched until the enable input changes level. Open load is filtered symmetrically and recovers without help. Overvoltage and overtemperature follow the monitor status with no memory.

The per-output overcurrent and open-load indications are ORed across all outputs. A fixed priority then reduces the three kinds to one 2-bit code. The code reaches the pins through a fixed delay line, so a change in a fault condition shows on the pins a set number of clock cycles later. All time windows are given in clock cycles.

Top module: `err_flag_encoder`

## Requirements
- R1: While reset is asserted, and after reset until a fault is captured, the pins read flag_a_n=1, flag_b_n=1.
- R2: The pin pair {flag_a_n, flag_b_n} is encoded as follows: 11 means no fault, 10 means overcurrent, 01 means open load, and 00 means overvoltage or overtemperature.
- R3: When several faults are active, overvoltage/overtemperature wins over overcurrent, and overcurrent wins over open load.
- R4: An overcurrent event on any output, present at one clock edge, sets a latch. The latch holds with no further events. It clears only at an edge where en_i differs from its value at the previous edge, or on reset. A clear and a new event at the same edge leave the latch cleared.
- R5: The open-load state of an output sets at the OL_DLY-th consecutive edge at which its low-side gate is on and its undercurrent bit is 1. The output switching itself is not touched. Any output in the open-load state gives an open-load indication.
- R6: A set open-load state clears at the OL_DLY-th consecutive edge at which the gate is on and the undercurrent bit is 0.
- R7: An edge at which the low-side gate is off leaves the open-load state unchanged and restarts that output's filter window.
- R8: Overvoltage and overtemperature are not latched. The indication ends as soon as both inputs are low.
- R9: The fault code formed from the inputs and state at a clock edge appears on the pins exactly EF_DLY edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also serves as the power-on reset |
| en_i | input | 1 | Device enable level; any change of level clears the overcurrent latch |
| oc_evt_i | input | NUM_OUT | Qualified overcurrent event, one bit per output |
| ls_on_i | input | NUM_OUT | Low-side gate status, one bit per output |
| ls_under_i | input | NUM_OUT | Raw low-side undercurrent comparator, one bit per output |
| ov_i | input | 1 | Supply overvoltage status |
| ot_i | input | 1 | Overtemperature status |
| flag_a_n_o | output | 1 | First active-low flag pin |
| flag_b_n_o | output | 1 | Second active-low flag pin |

## Verification
The bench builds the block with four outputs, OL_DLY=6 and EF_DLY=3. With windows this short, a run of some twenty thousand random cycles crosses many full open-load set and clear windows, and many windows cut short by a gate-off edge or a comparator flip. The short delay line lets every transition be checked at its exact edge. It also lets overlapping faults and enable toggles be seen racing through the priority logic within a few cycles.

// File: rtl/err_flag_encoder.sv
module err_flag_encoder #(
  parameter int NUM_OUT = 4,
  parameter int OL_DLY  = 16,
  parameter int EF_DLY  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [NUM_OUT-1:0] oc_evt_i,
  input  logic [NUM_OUT-1:0] ls_on_i,
  input  logic [NUM_OUT-1:0] ls_under_i,
  input  logic               ov_i,
  input  logic               ot_i,
  output logic               flag_a_n_o,
  output logic               flag_b_n_o
);
  localparam int CW = $clog2(OL_DLY + 1);
  localparam int RW = $clog2(EF_DLY + 1);

  logic               en_q;
  logic               en_chg;
  logic               oc_lat;
  logic [NUM_OUT-1:0] ol_st;
  logic [1:0]         code;
  logic [1:0]         pipe [EF_DLY];

  assign en_chg = en_i != en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      oc_lat <= 1'b0;
    end else begin
      en_q   <= en_i;
      oc_lat <= en_chg ? 1'b0 : (oc_lat | (|oc_evt_i));
    end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ol
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt      <= '0;
        ol_st[i] <= 1'b0;
      end else if (!ls_on_i[i] || (ls_under_i[i] == ol_st[i])) begin
        cnt <= '0;
      end else if (cnt == CW'(OL_DLY - 1)) begin
        cnt      <= '0;
        ol_st[i] <= ~ol_st[i];
      end else begin
        cnt <= cnt + 1'b1;
      end

    a_ol_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ol_st[i]) |-> $past(ls_on_i[i]));
  end

  assign code = (ov_i | ot_i) ? 2'b00 :
                oc_lat        ? 2'b10 :
                (|ol_st)      ? 2'b01 : 2'b11;

  for (genvar k = 0; k < EF_DLY; k++) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe[k] <= 2'b11;
      else if (k == 0) pipe[k] <= code;
      else pipe[k] <= pipe[(k == 0) ? 0 : k-1];
  end

  assign {flag_a_n_o, flag_b_n_o} = pipe[EF_DLY-1];

  logic [RW-1:0] ovot_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovot_run <= '0;
    else if (!(ov_i | ot_i)) ovot_run <= '0;
    else if (ovot_run != RW'(EF_DLY)) ovot_run <= ovot_run + 1'b1;

  a_ovot_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovot_run == RW'(EF_DLY)) |-> ({flag_a_n_o, flag_b_n_o} == 2'b00));

  a_oc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_lat) |-> $past(en_i != en_q));

  a_oc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|oc_evt_i) && (en_i == en_q)) |=> oc_lat);
endmodule

// File: tb/err_flag_encoder_bench.sv
module err_flag_encoder_bench;
  localparam int N  = 4;
  localparam int OL = 6;
  localparam int ED = 3;

  logic clk = 0, rst_n = 0, en_i = 1, ov_i = 0, ot_i = 0;
  logic [N-1:0] oc_evt_i = '0, ls_on_i = '0, ls_under_i = '0;
  logic fa, fb;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  err_flag_encoder #(.NUM_OUT(N), .OL_DLY(OL), .EF_DLY(ED)) u_err_flag_encoder (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .oc_evt_i(oc_evt_i), .ls_on_i(ls_on_i),
    .ls_under_i(ls_under_i), .ov_i(ov_i), .ot_i(ot_i),
    .flag_a_n_o(fa), .flag_b_n_o(fb));

  logic m_enq, m_oc;
  logic [N-1:0] m_ol;
  int m_cnt [N];
  logic [1:0] m_pipe [ED];

  function automatic logic [1:0] enc(logic ovot, logic oc, logic ol);
    if (ovot) return 2'b00;
    if (oc) return 2'b10;
    if (ol) return 2'b01;
    return 2'b11;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_enq = 0; m_oc = 0; m_ol = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
      for (int k = 0; k < ED; k++) m_pipe[k] = 2'b11;
    end else begin
      logic [1:0] c;
      c = enc(ov_i | ot_i, m_oc, |m_ol);
      for (int k = ED-1; k > 0; k--) m_pipe[k] = m_pipe[k-1];
      m_pipe[0] = c;
      if (en_i != m_enq) m_oc = 0; else if (|oc_evt_i) m_oc = 1;
      m_enq = en_i;
      for (int i = 0; i < N; i++) begin
        if (ls_on_i[i] && (ls_under_i[i] != m_ol[i])) begin
          m_cnt[i]++;
          if (m_cnt[i] == OL) begin m_ol[i] = ~m_ol[i]; m_cnt[i] = 0; end
        end else m_cnt[i] = 0;
      end
    end
  end

  task automatic chk(string tag);
    logic [1:0] exp;
    exp = m_pipe[ED-1];
    checks++;
    if ({fa, fb} !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d flags=%b expected=%b", tag, cyc, {fa, fb}, exp);
    end
  endtask

  task automatic step(string tag, int n = 1);
    for (int j = 0; j < n; j++) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      chk(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    step("R1 reset", 3);
    rst_n = 1;
    step("R1 idle", 4);
    ov_i = 1; step("R9 overvoltage delay", 6);
    ov_i = 0; step("R8 overvoltage release", 6);
    oc_evt_i = 4'b0100; step("R4 oc set");
    oc_evt_i = '0; step("R4 oc held", 8);
    ot_i = 1; step("R3 ot over oc", 6);
    ot_i = 0; step("R8 ot release", 5);
    en_i = 0; oc_evt_i = 4'b0001; step("R4 clear wins");
    oc_evt_i = '0; step("R4 cleared", 6);
    en_i = 1; step("R4 toggle back", 5);
    ls_on_i[1] = 1; ls_under_i[1] = 1; step("R5 ol set", OL + ED + 2);
    oc_evt_i = 4'b1000; step("R3 oc over ol");
    oc_evt_i = '0; step("R3 oc over ol", 5);
    en_i = 0; step("R5 ol after oc clear", 5);
    ls_on_i[1] = 0; ls_under_i[1] = 0; step("R7 gate off hold", 12);
    ls_on_i[1] = 1; step("R6 ol clear", OL - 2);
    ls_on_i[1] = 0; step("R7 window restart");
    ls_on_i[1] = 1; step("R7 window restart", OL + ED + 2);
    ls_under_i[2] = 1; ls_on_i[2] = 1; step("R5 short burst", OL - 1);
    ls_under_i[2] = 0; step("R5 short burst", OL + ED);
    ls_on_i = '0; ls_under_i = '0;
    step("R2 idle", 4);
    for (int t = 0; t < 20000; t++) begin
      if ($urandom_range(63) == 0) oc_evt_i = N'($urandom); else oc_evt_i = '0;
      if ($urandom_range(79) == 0) en_i = ~en_i;
      if ($urandom_range(7) == 0) ls_on_i = N'($urandom);
      if ($urandom_range(5) == 0) ls_under_i = N'($urandom);
      if ($urandom_range(149) == 0) ov_i = ~ov_i;
      if ($urandom_range(199) == 0) ot_i = ~ot_i;
      case (m_pipe[ED-1])
        2'b00: step("R8 random");
        2'b10: step("R4 random");
        2'b01: step("R5 random");
        default: step("R2 random");
      endcase
    end
    finish_run();
  end
endmodule